// File: doc/BRIEF.md
# Mixed Radix-4 / Radix-2 FFT Butterfly Engine

This block is the arithmetic core of a sequential, in-place FFT processor. Each operation takes four complex fixed-point samples, up to three complex twiddle factors and a mode bit. In radix-4 mode the four samples form one decimation-in-frequency radix-4 butterfly. In radix-2 mode they form two independent radix-2 butterflies, and both complete in the same operation slot. The surrounding controller supplies operands from its working memory and writes results back. Addressing, memories and twiddle tables sit outside this block.

Each result is scaled down before it leaves the block, so that repeated passes over the data cannot overflow. Radix-4 results are divided by four and radix-2 results by two, with rounding, and the result then saturates to the data width. The `SHARE_MULT` parameter selects the multiplier build. When it is 0, there are four real multipliers per twiddled lane and the block accepts one operation every clock. When it is 1, each complex product uses two real multipliers over two clocks. The block then accepts an operation only on every second cycle and signals this on `in_accept`.

Top module: `mrb_butterfly`

## Requirements
- R1: While reset is asserted and directly after it, `out_valid` is 0 and `out_re`/`out_im` read zero.
- R2: Lane k (k=0..3) of each sample bus occupies bits [k*DW +: DW]. Twiddle slot k (k=1..3) occupies bits [(k-1)*TW +: TW] and is a signed Q1.15 value. `in_mode`=1 selects radix-4 and 0 selects radix-2.
- R3: In radix-4 mode, with a..d on lanes 0..3, the lanes before twiddling are: lane0 = a+b+c+d; lane1 = (a−c) − j(b−d); lane2 = (a+c) − (b+d); lane3 = (a−c) + j(b−d).
- R4: In radix-2 mode, lane0 = a+b, lane1 = a−b, lane2 = c+d and lane3 = c−d.
- R5: Lane0 is never multiplied. In radix-4 mode, lanes 1..3 are multiplied by twiddle slots 1..3. In radix-2 mode, only lanes 1 and 3 are multiplied, by slots 1 and 3. Slot 2 has no effect in radix-2 mode.
- R6: Each complex product is divided by 2^15 and then by 4 (radix-4) or 2 (radix-2), rounding half toward +infinity. For example, a radix-4 lane0 value of 2 gives 1 and a value of −2 gives 0.
- R7: A result outside the signed DW-bit range saturates to 32767 or −32768.
- R8: With `SHARE_MULT`=0, `in_accept` is always 1. A new operation can enter every cycle. Its result and `out_valid`=1 appear after the fourth rising edge, counting the edge that captured it.
- R9: With `SHARE_MULT`=1, `in_accept` is 0 in the first cycle after reset and then toggles every cycle. `in_valid` and the operands are ignored while `in_accept` is 0.
- R10: With `SHARE_MULT`=1, a captured operation's result appears after the seventh rising edge, counting the capture edge. `out_valid` is high for exactly one cycle. The values are identical to those of the full-rate build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present on the inputs |
| in_mode | input | 1 | 1 = one radix-4 butterfly, 0 = two radix-2 butterflies |
| in_re | input | 4*DW | Real parts of the four input samples |
| in_im | input | 4*DW | Imaginary parts of the four input samples |
| tw_re | input | 3*TW | Real parts of twiddle slots 1..3 |
| tw_im | input | 3*TW | Imaginary parts of twiddle slots 1..3 |
| in_accept | output | 1 | Inputs are sampled at the next rising edge |
| out_valid | output | 1 | Result lanes are valid |
| out_re | output | 4*DW | Real parts of the four results |
| out_im | output | 4*DW | Imaginary parts of the four results |

## Verification
In the full-rate build, an operation driven before rising edge E has its result sampled at the falling edge four clocks later. The stimulus table is streamed one operation per cycle, and each output is compared with the vector issued four cycles earlier. In the shared build, operations are driven only in a cycle where `in_accept` is high. `out_valid` is watched at each of the eight following falling edges and must be high only at the seventh, where the data is compared. Directed single operations are sampled four falling edges after they are driven, with the inputs idle in between.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
   typedef enum logic {
      MODE_PAIR2 = 1'b0,
      MODE_QUAD4 = 1'b1
   } bfly_mode_e;
endpackage

// File: rtl/mrb_combine.sv
// Stage 1: add/subtract network. Registered, advances on en.
module mrb_combine
   import mrb_pkg::*;
#(
   parameter int DW = 16,
   parameter int XW = DW + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  bfly_mode_e           mode,
   input  logic signed [DW-1:0] a_re [4],
   input  logic signed [DW-1:0] a_im [4],
   output logic signed [XW-1:0] x_re [4],
   output logic signed [XW-1:0] x_im [4]
);
   if (XW < DW + 2) begin : g_bad_xw
      $error("mrb_combine: XW must leave two bits of growth");
   end

   logic signed [XW-1:0] sr [4];
   logic signed [XW-1:0] si [4];
   logic signed [XW-1:0] nr [4];
   logic signed [XW-1:0] ni [4];
   logic signed [XW-1:0] dac_r, dac_i, dbd_r, dbd_i;

   always_comb begin
      for (int k = 0; k < 4; k++) begin
         sr[k] = XW'(a_re[k]);
         si[k] = XW'(a_im[k]);
      end
      dac_r = sr[0] - sr[2];
      dac_i = si[0] - si[2];
      dbd_r = sr[1] - sr[3];
      dbd_i = si[1] - si[3];
      if (mode == MODE_QUAD4) begin
         nr[0] = (sr[0] + sr[2]) + (sr[1] + sr[3]);
         ni[0] = (si[0] + si[2]) + (si[1] + si[3]);
         // -j*(b-d) adds (bi-di) to real, subtracts (br-dr) from imag
         nr[1] = dac_r + dbd_i;
         ni[1] = dac_i - dbd_r;
         nr[2] = (sr[0] + sr[2]) - (sr[1] + sr[3]);
         ni[2] = (si[0] + si[2]) - (si[1] + si[3]);
         nr[3] = dac_r - dbd_i;
         ni[3] = dac_i + dbd_r;
      end else begin
         nr[0] = sr[0] + sr[1];
         ni[0] = si[0] + si[1];
         nr[1] = sr[0] - sr[1];
         ni[1] = si[0] - si[1];
         nr[2] = sr[2] + sr[3];
         ni[2] = si[2] + si[3];
         nr[3] = sr[2] - sr[3];
         ni[3] = si[2] - si[3];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < 4; k++) begin
            x_re[k] <= '0;
            x_im[k] <= '0;
         end
      end else if (en) begin
         for (int k = 0; k < 4; k++) begin
            x_re[k] <= nr[k];
            x_im[k] <= ni[k];
         end
      end
   end
endmodule

// File: rtl/mrb_cmul.sv
// Stage 2: complex multiply, full-rate or two-cycle shared variant.
module mrb_cmul #(
   parameter int XW    = 18,
   parameter int WW    = 17,
   parameter int PW    = XW + WW + 1,
   parameter bit SHARE = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ph,
   input  logic signed [XW-1:0] x_re,
   input  logic signed [XW-1:0] x_im,
   input  logic signed [WW-1:0] w_re,
   input  logic signed [WW-1:0] w_im,
   output logic signed [PW-1:0] p_re,
   output logic signed [PW-1:0] p_im
);
   localparam int MW = XW + WW;

   if (PW < MW + 1) begin : g_bad_pw
      $error("mrb_cmul: PW too narrow for a complex product");
   end

   if (!SHARE) begin : g_full
      logic signed [MW-1:0] rr, ii, ri, ir;
      assign rr = MW'(x_re) * MW'(w_re);
      assign ii = MW'(x_im) * MW'(w_im);
      assign ri = MW'(x_re) * MW'(w_im);
      assign ir = MW'(x_im) * MW'(w_re);

      // ph is held low in the full-rate build: update every cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            p_re <= '0;
            p_im <= '0;
         end else if (!ph) begin
            p_re <= PW'(rr) - PW'(ii);
            p_im <= PW'(ri) + PW'(ir);
         end
      end
   end else begin : g_shared
      logic signed [WW-1:0] w0, w1;
      logic signed [MW-1:0] m0, m1;
      logic signed [PW-1:0] hold_re;

      // phase 0: xr*wr, xi*wi ; phase 1: xr*wi, xi*wr
      assign w0 = ph ? w_im : w_re;
      assign w1 = ph ? w_re : w_im;
      assign m0 = MW'(x_re) * MW'(w0);
      assign m1 = MW'(x_im) * MW'(w1);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_re <= '0;
            p_re    <= '0;
            p_im    <= '0;
         end else if (!ph) begin
            hold_re <= PW'(m0) - PW'(m1);
         end else begin
            p_re <= hold_re;
            p_im <= PW'(m0) + PW'(m1);
         end
      end
   end
endmodule

// File: rtl/mrb_round.sv
// Stage 3: mode-dependent shift, round half up, saturate.
module mrb_round #(
   parameter int PW = 36,
   parameter int DW = 16,
   parameter int TW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 quad,
   input  logic signed [PW-1:0] p_re,
   input  logic signed [PW-1:0] p_im,
   output logic signed [DW-1:0] y_re,
   output logic signed [DW-1:0] y_im
);
   localparam int SH2 = TW;
   localparam int SH4 = TW + 1;
   localparam logic signed [PW:0] BIAS2 = (PW+1)'(1) <<< (SH2 - 1);
   localparam logic signed [PW:0] BIAS4 = (PW+1)'(1) <<< (SH4 - 1);
   localparam logic signed [PW:0] HI    = (PW+1)'((longint'(1) <<< (DW - 1)) - 1);
   localparam logic signed [PW:0] LO    = ~HI;

   if (PW <= SH4 + DW) begin : g_bad_pw
      $error("mrb_round: PW too narrow for the shift");
   end

   function automatic logic signed [DW-1:0] fix(input logic signed [PW-1:0] p,
                                                input logic q);
      logic signed [PW:0] b;
      logic signed [PW:0] s;
      b = (PW+1)'(p) + (q ? BIAS4 : BIAS2);
      s = q ? (b >>> SH4) : (b >>> SH2);
      if (s > HI)      return DW'(HI);
      else if (s < LO) return DW'(LO);
      else             return DW'(s);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         y_re <= '0;
         y_im <= '0;
      end else if (en) begin
         y_re <= fix(p_re, quad);
         y_im <= fix(p_im, quad);
      end
   end
endmodule

// File: rtl/mrb_butterfly.sv
module mrb_butterfly
   import mrb_pkg::*;
#(
   parameter int DW         = 16,
   parameter int TW         = 16,
   parameter bit SHARE_MULT = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic            in_mode,
   input  logic [4*DW-1:0] in_re,
   input  logic [4*DW-1:0] in_im,
   input  logic [3*TW-1:0] tw_re,
   input  logic [3*TW-1:0] tw_im,
   output logic            in_accept,
   output logic            out_valid,
   output logic [4*DW-1:0] out_re,
   output logic [4*DW-1:0] out_im
);
   localparam int XW = DW + 2;
   localparam int WW = TW + 1;
   localparam int PW = XW + WW + 1;
   localparam logic signed [WW-1:0] UNITY = WW'(longint'(1) <<< (TW - 1));

   if (DW < 4 || DW > 24) begin : g_bad_dw
      $error("mrb_butterfly: DW out of range");
   end
   if (TW < 4 || TW > 24) begin : g_bad_tw
      $error("mrb_butterfly: TW out of range");
   end

   // ---------------- phase / step ----------------
   logic ph, step;
   if (SHARE_MULT) begin : g_phase
      logic ph_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ph_q <= 1'b0;
         else        ph_q <= ~ph_q;
      end
      assign ph   = ph_q;
      assign step = ph_q;
   end else begin : g_nophase
      assign ph   = 1'b0;
      assign step = 1'b1;
   end
   assign in_accept = step;

   // ---------------- stage 0: input capture ----------------
   logic                 v0, v1, v2, v3;
   bfly_mode_e           md0, md1, md2;
   logic signed [DW-1:0] s0_re [4];
   logic signed [DW-1:0] s0_im [4];
   logic signed [TW-1:0] s0_wr [1:3];
   logic signed [TW-1:0] s0_wi [1:3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v0  <= 1'b0;
         md0 <= MODE_PAIR2;
         for (int k = 0; k < 4; k++) begin
            s0_re[k] <= '0;
            s0_im[k] <= '0;
         end
         for (int k = 1; k < 4; k++) begin
            s0_wr[k] <= '0;
            s0_wi[k] <= '0;
         end
      end else if (step) begin
         v0  <= in_valid;
         md0 <= bfly_mode_e'(in_mode);
         for (int k = 0; k < 4; k++) begin
            s0_re[k] <= in_re[k*DW +: DW];
            s0_im[k] <= in_im[k*DW +: DW];
         end
         for (int k = 1; k < 4; k++) begin
            s0_wr[k] <= tw_re[(k-1)*TW +: TW];
            s0_wi[k] <= tw_im[(k-1)*TW +: TW];
         end
      end
   end

   // ---------------- stage 1: add/sub + twiddle select ----------------
   logic signed [XW-1:0] x_re [4];
   logic signed [XW-1:0] x_im [4];
   logic signed [WW-1:0] w1_re [1:3];
   logic signed [WW-1:0] w1_im [1:3];

   mrb_combine #(.DW(DW), .XW(XW)) u_comb (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (step),
      .mode (md0),
      .a_re (s0_re),
      .a_im (s0_im),
      .x_re (x_re),
      .x_im (x_im)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1  <= 1'b0;
         md1 <= MODE_PAIR2;
         for (int k = 1; k < 4; k++) begin
            w1_re[k] <= '0;
            w1_im[k] <= '0;
         end
      end else if (step) begin
         v1  <= v0;
         md1 <= md0;
         for (int k = 1; k < 4; k++) begin
            if (k == 2 && md0 == MODE_PAIR2) begin
               w1_re[k] <= UNITY;   // sum lane of the upper pair
               w1_im[k] <= '0;
            end else begin
               w1_re[k] <= WW'(s0_wr[k]);
               w1_im[k] <= WW'(s0_wi[k]);
            end
         end
      end
   end

   // ---------------- stage 2: products ----------------
   logic signed [PW-1:0] p_re [4];
   logic signed [PW-1:0] p_im [4];

   for (genvar g = 0; g < 4; g++) begin : g_lane
      if (g == 0) begin : g_pass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               p_re[g] <= '0;
               p_im[g] <= '0;
            end else if (step) begin
               p_re[g] <= PW'(x_re[g]) <<< (TW - 1);
               p_im[g] <= PW'(x_im[g]) <<< (TW - 1);
            end
         end
      end else begin : g_mul
         mrb_cmul #(.XW(XW), .WW(WW), .PW(PW), .SHARE(SHARE_MULT)) u_cmul (
            .clk  (clk),
            .rst_n(rst_n),
            .ph   (ph),
            .x_re (x_re[g]),
            .x_im (x_im[g]),
            .w_re (w1_re[g]),
            .w_im (w1_im[g]),
            .p_re (p_re[g]),
            .p_im (p_im[g])
         );
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v2  <= 1'b0;
         md2 <= MODE_PAIR2;
      end else if (step) begin
         v2  <= v1;
         md2 <= md1;
      end
   end

   // ---------------- stage 3: scale and output ----------------
   logic signed [DW-1:0] y_re [4];
   logic signed [DW-1:0] y_im [4];

   for (genvar g = 0; g < 4; g++) begin : g_out
      mrb_round #(.PW(PW), .DW(DW), .TW(TW)) u_rnd (
         .clk  (clk),
         .rst_n(rst_n),
         .en   (step),
         .quad (md2 == MODE_QUAD4),
         .p_re (p_re[g]),
         .p_im (p_im[g]),
         .y_re (y_re[g]),
         .y_im (y_im[g])
      );
      assign out_re[g*DW +: DW] = y_re[g];
      assign out_im[g*DW +: DW] = y_im[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    v3 <= 1'b0;
      else if (step) v3 <= v2;
   end

   assign out_valid = SHARE_MULT ? (v3 & ~ph) : v3;
endmodule

// File: rtl/mrb_butterfly_chk.sv
module mrb_butterfly_chk #(
   parameter bit SHARE = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_accept,
   input logic out_valid
);
   localparam int LAT = SHARE ? 7 : 4;

   logic [3:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                age <= '0;
      else if (age != 4'(LAT))   age <= age + 4'd1;
   end

   // result valid exactly LAT sampled edges after an accepted operation
   AST_LATENCY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 4'(LAT)) |-> (out_valid == $past(in_valid && in_accept, LAT))) // R8
      else $error("latency mismatch");

   if (SHARE) begin : g_sh
      AST_ACCEPT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
         in_accept |=> !in_accept) // R9
         else $error("accept held two cycles");
      AST_ACCEPT_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
         !in_accept |=> in_accept) // R9
         else $error("accept low two cycles");
      AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |=> !out_valid) // R10
         else $error("valid longer than one cycle");
   end
endmodule

bind mrb_butterfly mrb_butterfly_chk #(.SHARE(SHARE_MULT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_accept(in_accept),
   .out_valid(out_valid)
);

// File: tb/mrb_butterfly_test.sv
module mrb_butterfly_test;
   typedef struct packed {
      logic        mode;
      logic [63:0] re;
      logic [63:0] im;
      logic [47:0] wr;
      logic [47:0] wi;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t TBL [NV] = '{
      '{1'b1, 64'h0001_0002_0003_0004, 64'h0000_0000_0000_0000, 48'h7FFF_7FFF_7FFF, 48'h0000_0000_0000},
      '{1'b1, 64'h1000_F000_0800_0400, 64'h0123_FEDC_7000_9000, 48'h5A82_0000_A57E, 48'hA57E_8000_A57E},
      '{1'b0, 64'h7FFF_8000_1234_4321, 64'h0100_FF00_0ABC_F543, 48'h5A82_7FFF_0000, 48'hA57E_0000_8000},
      '{1'b1, 64'h7FFF_7FFF_7FFF_7FFF, 64'h8000_8000_8000_8000, 48'h7FFF_7FFF_7FFF, 48'h7FFF_7FFF_7FFF},
      '{1'b0, 64'h0003_FFFD_0001_FFFF, 64'h0002_0002_FFFE_0001, 48'h4000_0000_C000, 48'h0000_4000_4000},
      '{1'b1, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 48'h8000_8000_8000, 48'h0000_0000_0000},
      '{1'b0, 64'h2222_3333_4444_5555, 64'h6666_7777_8888_9999, 48'h1111_2222_3333, 48'hEEEE_DDDD_CCCC},
      '{1'b1, 64'hF00D_BEEF_0F0F_AAAA, 64'h5555_1357_2468_ACE0, 48'h6A6A_1F1F_C3C3, 48'h9C9C_7070_0101}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        f_valid = 1'b0, f_mode = 1'b0;
   logic [63:0] f_re = '0, f_im = '0;
   logic [47:0] f_wr = '0, f_wi = '0;
   logic        f_acc, f_ov;
   logic [63:0] f_ore, f_oim;

   logic        s_valid = 1'b0, s_mode = 1'b0;
   logic [63:0] s_re = '0, s_im = '0;
   logic [47:0] s_wr = '0, s_wi = '0;
   logic        s_acc, s_ov;
   logic [63:0] s_ore, s_oim;

   mrb_butterfly #(.DW(16), .TW(16), .SHARE_MULT(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(f_valid), .in_mode(f_mode),
      .in_re(f_re), .in_im(f_im), .tw_re(f_wr), .tw_im(f_wi),
      .in_accept(f_acc), .out_valid(f_ov), .out_re(f_ore), .out_im(f_oim));

   mrb_butterfly #(.DW(16), .TW(16), .SHARE_MULT(1'b1)) uut_sh (
      .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_mode(s_mode),
      .in_re(s_re), .in_im(s_im), .tw_re(s_wr), .tw_im(s_wi),
      .in_accept(s_acc), .out_valid(s_ov), .out_re(s_ore), .out_im(s_oim));

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   task automatic check(input bit ok, input string tag,
                        input logic [127:0] act, input logic [127:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] rs(input longint p, input int sh);
      longint r;
      r = (p + (longint'(1) <<< (sh - 1))) >>> sh;
      if (r > 32767)       r = 32767;
      else if (r < -32768) r = -32768;
      return r[15:0];
   endfunction

   // reference built from R2..R7
   function automatic logic [127:0] model(input vec_t v);
      longint ar[4], ai[4], xr[4], xi[4], wr[4], wi[4];
      logic [63:0] ore, oim;
      int sh;
      for (int k = 0; k < 4; k++) begin
         ar[k] = longint'($signed(v.re[k*16 +: 16]));
         ai[k] = longint'($signed(v.im[k*16 +: 16]));
      end
      wr[0] = 32768; wi[0] = 0;
      for (int k = 1; k < 4; k++) begin
         wr[k] = longint'($signed(v.wr[(k-1)*16 +: 16]));
         wi[k] = longint'($signed(v.wi[(k-1)*16 +: 16]));
      end
      if (v.mode) begin
         xr[0] = ar[0] + ar[1] + ar[2] + ar[3];
         xi[0] = ai[0] + ai[1] + ai[2] + ai[3];
         xr[1] = (ar[0] - ar[2]) + (ai[1] - ai[3]);
         xi[1] = (ai[0] - ai[2]) - (ar[1] - ar[3]);
         xr[2] = (ar[0] + ar[2]) - (ar[1] + ar[3]);
         xi[2] = (ai[0] + ai[2]) - (ai[1] + ai[3]);
         xr[3] = (ar[0] - ar[2]) - (ai[1] - ai[3]);
         xi[3] = (ai[0] - ai[2]) + (ar[1] - ar[3]);
         sh = 17;
      end else begin
         xr[0] = ar[0] + ar[1]; xi[0] = ai[0] + ai[1];
         xr[1] = ar[0] - ar[1]; xi[1] = ai[0] - ai[1];
         xr[2] = ar[2] + ar[3]; xi[2] = ai[2] + ai[3];
         xr[3] = ar[2] - ar[3]; xi[3] = ai[2] - ai[3];
         wr[2] = 32768; wi[2] = 0;
         sh = 16;
      end
      for (int k = 0; k < 4; k++) begin
         ore[k*16 +: 16] = rs(xr[k] * wr[k] - xi[k] * wi[k], sh);
         oim[k*16 +: 16] = rs(xr[k] * wi[k] + xi[k] * wr[k], sh);
      end
      return {ore, oim};
   endfunction

   task automatic drive_f(input vec_t v, input logic vld);
      f_valid = vld; f_mode = v.mode; f_re = v.re; f_im = v.im;
      f_wr = v.wr; f_wi = v.wi;
   endtask

   task automatic drive_s(input vec_t v, input logic vld);
      s_valid = vld; s_mode = v.mode; s_re = v.re; s_im = v.im;
      s_wr = v.wr; s_wi = v.wi;
   endtask

   // single full-rate operation, result sampled 4 falling edges later
   task automatic full_op(input vec_t v, output logic [127:0] got, output logic vld);
      @(negedge clk); drive_f(v, 1'b1);
      @(negedge clk); f_valid = 1'b0;
      repeat (3) @(negedge clk);
      got = {f_ore, f_oim};
      vld = f_ov;
   endtask

   // shared operation: garbage while accept is low, real vector on accept
   task automatic shared_op(input vec_t v, input vec_t junk);
      logic [127:0] exp;
      bit pat_ok;
      exp = model(v);
      do @(negedge clk); while (s_acc);
      drive_s(junk, 1'b1);
      @(negedge clk);
      check(s_acc == 1'b1, "R9 accept returns high", {127'd0, s_acc}, 128'd1);
      drive_s(v, 1'b1);
      pat_ok = 1'b1;
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         if (k == 1) s_valid = 1'b0;
         if (s_ov != (k == 7)) pat_ok = 1'b0;
         if (k == 7)
            check({s_ore, s_oim} == exp, "R10 shared result equals reference", {s_ore, s_oim}, exp);
      end
      check(pat_ok, "R10/R9 single valid pulse 7 edges after capture", {127'd0, pat_ok}, 128'd1);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [127:0] got;
      logic vld;
      vec_t v;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(f_ov == 1'b0 && s_ov == 1'b0, "R1 valid low in reset", {126'd0, f_ov, s_ov}, 128'd0);
      check({f_ore, f_oim} == 128'd0, "R1 outputs zero in reset", {f_ore, f_oim}, 128'd0);
      rst_n = 1'b1;
      check(s_acc == 1'b0, "R9 accept low first cycle after reset", {127'd0, s_acc}, 128'd0);
      check(f_acc == 1'b1, "R8 full-rate accept high", {127'd0, f_acc}, 128'd1);

      // R2..R8: stream the table back to back
      for (int t = 0; t < NV + 4; t++) begin
         @(negedge clk);
         if (t >= 4) begin
            check(f_ov == 1'b1, "R8 valid 4 edges after capture", {127'd0, f_ov}, 128'd1);
            check({f_ore, f_oim} == model(TBL[t-4]),
                  TBL[t-4].mode ? "R3/R5/R6 radix-4 vector" : "R4/R5/R6 radix-2 vector",
                  {f_ore, f_oim}, model(TBL[t-4]));
         end else begin
            check(f_ov == 1'b0, "R1 no valid before first result", {127'd0, f_ov}, 128'd0);
         end
         if (t < NV) drive_f(TBL[t], 1'b1);
         else        f_valid = 1'b0;
      end

      // R6: rounding, radix-4 lane0 value 2 -> 1, value -2 -> 0
      v = '{1'b1, 64'h0000_0000_0000_0002, 64'd0, 48'd0, 48'd0};
      full_op(v, got, vld);
      check(got[79:64] == 16'h0001, "R6 radix-4 +0.5 rounds up", {112'd0, got[79:64]}, 128'd1);
      v.re = 64'h0000_0000_0000_FFFE;
      full_op(v, got, vld);
      check(got[79:64] == 16'h0000, "R6 radix-4 -0.5 rounds to 0", {112'd0, got[79:64]}, 128'd0);

      // R6: radix-2 lane0 value 1 -> 1, lane1 1*0.99997 -> 0
      v = '{1'b0, 64'h0000_0000_0000_0001, 64'd0, 48'h0000_0000_7FFF, 48'd0};
      full_op(v, got, vld);
      check(got[79:64] == 16'h0001 && got[95:80] == 16'h0000, "R6 radix-2 rounding",
            {96'd0, got[95:64]}, {96'd0, 32'h0000_0001});
      v.re = 64'h0000_0000_0000_FFFF;
      full_op(v, got, vld);
      check(got[79:64] == 16'h0000, "R6 radix-2 -0.5 rounds to 0", {112'd0, got[79:64]}, 128'd0);

      // R7: saturation both ways on lane1 imaginary
      v = '{1'b1, 64'h7FFF_8000_8000_7FFF, 64'h8000_8000_7FFF_7FFF,
            48'h0000_0000_8000, 48'h0000_0000_8000};
      full_op(v, got, vld);
      check(got[31:16] == 16'h8000 && got[95:80] == 16'h0000, "R7 negative saturation",
            {96'd0, got[95:80], got[31:16]}, {96'd0, 32'h0000_8000});
      v.wr = 48'h0000_0000_7FFF; v.wi = 48'h0000_0000_7FFF;
      full_op(v, got, vld);
      check(got[31:16] == 16'h7FFF && got[95:80] == 16'h0000, "R7 positive saturation",
            {96'd0, got[95:80], got[31:16]}, {96'd0, 32'h0000_7FFF});

      // R5: slot 2 ignored in radix-2 mode
      v = TBL[2];
      v.wr[31:16] = 16'h1234; v.wi[31:16] = 16'hC321;
      full_op(v, got, vld);
      check(got == model(TBL[2]), "R5 slot 2 ignored in radix-2", got, model(TBL[2]));

      // R9/R10: shared-multiplier build
      shared_op(TBL[1], TBL[7]);
      shared_op(TBL[6], TBL[3]);
      shared_op(TBL[3], TBL[0]);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule